// File: doc/BRIEF.md
# Low-Power Mode Controller

This controller moves a small microcontroller between three power states: running, a deep sleep that stops the whole chip, and a light sleep that keeps the clock and counters alive. Software picks a sleep depth by writing one-shot request bits into a mode register. The block then drives enable lines for the main oscillator, the watchdog, the periodic timer, the brown-out detector and the low-battery detector. It also drives a run signal that stalls the core.

Only the multi-input wakeup request can release deep sleep. That request arrives asynchronously and passes through a synchroniser. After a deep-sleep wakeup the oscillator runs alone for a fixed warm-up period, counted in cycles of the always-on reference clock, and only then is the core released. A light-sleep wakeup comes from a timer overflow pulse or from the wakeup request, and the core restarts on the following cycle. On every resume the block raises a pending flag. Software drops that flag by writing zero to a separate clear register.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the block is running. Every enable output and `core_run` are 1, and `pmc_pending` is 0.
- R2: A write with `wr_addr`=0 and `wr_data` bit 0 set, made while running, enters deep sleep from the next cycle. All five enables and `core_run` are then 0.
- R3: A write with `wr_addr`=0 and `wr_data` bit 1 set (bit 0 clear), made while running, enters light sleep. In light sleep `osc_en`, `wdt_en` and `tmr_en` are 1, while `bod_en`, `lbd_en` and `core_run` are 0.
- R4: When bits 0 and 1 are both set in one write, deep sleep is entered.
- R5: In deep sleep a `tmr_ovf` pulse has no effect. All outputs stay 0.
- R6: A wakeup request in deep sleep is sampled through SYNC_STAGES (2) flip-flops. The block then enters warm-up, where only `osc_en` is 1. After exactly WARM_CYCLES cycles (default 32) `core_run` and all enables return to 1.
- R7: In light sleep, `core_run` is 1 in the cycle after the clock edge at which `tmr_ovf` is sampled high.
- R8: In light sleep, a wakeup request resumes the core once it has passed through the two-stage synchroniser.
- R9: The request bits clear themselves. After a resume the block stays running with no further write.
- R10: `pmc_pending` goes to 1 on each resume. A write with `wr_addr`=1 and `wr_data`=0 clears it. A nonzero write to that address leaves it unchanged.
- R11: If the synchronised wakeup request is already high when deep sleep is entered, the block leaves deep sleep after one cycle and starts warm-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the mode register, 1 selects the clear register |
| wr_data | input | 8 | Write data |
| wake_async | input | 1 | Asynchronous multi-input wakeup request |
| tmr_ovf | input | 1 | Timer overflow pulse |
| osc_en | output | 1 | Main oscillator enable |
| wdt_en | output | 1 | Watchdog enable |
| tmr_en | output | 1 | Timer enable |
| bod_en | output | 1 | Brown-out detector enable |
| lbd_en | output | 1 | Low-battery detector enable |
| core_run | output | 1 | Core may execute |
| pmc_pending | output | 1 | A resume is waiting to be acknowledged |

## Verification
The mode register is written with bit 0 alone, bit 1 alone and both bits together. The three cases show whether the decode and its priority pick the right sleep depth. Each sleep state is then driven by a timer pulse, by a wakeup request, or by a wakeup request that was already high beforehand. These patterns distinguish the wake sources each state accepts, the synchroniser latency and the warm-up length. Clear-register writes with zero and with nonzero data show that only the zero write drops the pending flag.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_HALT = 2'd1,
        PM_WARM = 2'd2,
        PM_IDLE = 2'd3
    } pm_state_e;

    localparam int MODE_HALT_BIT = 0;
    localparam int MODE_IDLE_BIT = 1;

    typedef struct packed {
        logic osc;
        logic wdt;
        logic tmr;
        logic bod;
        logic lbd;
        logic core;
    } pm_en_t;

    function automatic pm_en_t pm_enables(pm_state_e s);
        pm_en_t e;
        case (s)
            PM_RUN:  e = '{osc: 1'b1, wdt: 1'b1, tmr: 1'b1, bod: 1'b1, lbd: 1'b1, core: 1'b1};
            PM_IDLE: e = '{osc: 1'b1, wdt: 1'b1, tmr: 1'b1, bod: 1'b0, lbd: 1'b0, core: 1'b0};
            PM_WARM: e = '{osc: 1'b1, wdt: 1'b0, tmr: 1'b0, bod: 1'b0, lbd: 1'b0, core: 1'b0};
            default: e = '0;
        endcase
        return e;
    endfunction

    function automatic int unsigned warm_cycles(int unsigned hz);
        return (hz < 1000) ? 1 : hz / 1000;
    endfunction

endpackage

// File: rtl/lpm_wake_sync.sv
module lpm_wake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lpm_warmup_cnt.sv
module lpm_warmup_cnt #(
    parameter int unsigned CYCLES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !active) cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign done = active && (cnt_q == LAST);

    // R6
    warm_cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(active) |-> cnt_q == '0);
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      halt_req,
    input  logic      idle_req,
    input  logic      wake,
    input  logic      ovf,
    input  logic      warm_done,
    output pm_state_e state,
    output logic      resume
);
    pm_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        resume  = 1'b0;
        unique case (state_q)
            PM_RUN: begin
                if (halt_req)      state_d = PM_HALT;
                else if (idle_req) state_d = PM_IDLE;
            end
            PM_HALT: if (wake) state_d = PM_WARM;
            PM_WARM: if (warm_done) begin
                state_d = PM_RUN;
                resume  = 1'b1;
            end
            PM_IDLE: if (wake || ovf) begin
                state_d = PM_RUN;
                resume  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PM_RUN;
        else     state_q <= state_d;
    end

    assign state = state_q;

    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_HALT && !wake) |=> state_q == PM_HALT);
    // R7
    idle_resume_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_IDLE && ovf) |=> state_q == PM_RUN);
    // R4
    halt_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_RUN && halt_req && idle_req) |=> state_q == PM_HALT);
    // R6
    warm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_WARM && !warm_done) |=> state_q == PM_WARM);
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 32768,
    parameter int unsigned WARM_CYCLES = warm_cycles(CLK_HZ),
    parameter int          SYNC_STAGES = 2,
    parameter int          DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wake_async,
    input  logic              tmr_ovf,
    output logic              osc_en,
    output logic              wdt_en,
    output logic              tmr_en,
    output logic              bod_en,
    output logic              lbd_en,
    output logic              core_run,
    output logic              pmc_pending
);
    logic      wake_s, warm_done, resume;
    logic      halt_req, idle_req, clr_wr;
    pm_state_e state;
    pm_en_t    en;

    assign halt_req = wr_en && !wr_addr && wr_data[MODE_HALT_BIT];
    assign idle_req = wr_en && !wr_addr && wr_data[MODE_IDLE_BIT];
    assign clr_wr   = wr_en &&  wr_addr && (wr_data == '0);

    lpm_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_async(wake_async), .q_sync(wake_s)
    );

    lpm_warmup_cnt #(.CYCLES(WARM_CYCLES)) u_warm (
        .clk(clk), .rst(rst), .active(state == PM_WARM), .done(warm_done)
    );

    lpm_fsm u_fsm (
        .clk(clk), .rst(rst), .halt_req(halt_req), .idle_req(idle_req),
        .wake(wake_s), .ovf(tmr_ovf), .warm_done(warm_done),
        .state(state), .resume(resume)
    );

    always_ff @(posedge clk) begin
        if (rst)         pmc_pending <= 1'b0;
        else if (resume) pmc_pending <= 1'b1;
        else if (clr_wr) pmc_pending <= 1'b0;
    end

    assign en       = pm_enables(state);
    assign osc_en   = en.osc;
    assign wdt_en   = en.wdt;
    assign tmr_en   = en.tmr;
    assign bod_en   = en.bod;
    assign lbd_en   = en.lbd;
    assign core_run = en.core;

    // R10
    pend_on_resume_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(core_run) |-> pmc_pending);
    // R2
    halt_all_off_chk: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> !(wdt_en || tmr_en || bod_en || lbd_en || core_run));
    // R3
    detectors_need_core_chk: assert property (@(posedge clk) disable iff (rst)
        (bod_en || lbd_en) |-> core_run);
endmodule

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
    localparam int WARM = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_addr = 1'b0, wake_async = 1'b0, tmr_ovf = 1'b0;
    logic [7:0] wr_data = '0;
    logic       osc_en, wdt_en, tmr_en, bod_en, lbd_en, core_run, pmc_pending;
    int         n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    lpm_ctrl u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wake_async(wake_async), .tmr_ovf(tmr_ovf),
        .osc_en(osc_en), .wdt_en(wdt_en), .tmr_en(tmr_en), .bod_en(bod_en),
        .lbd_en(lbd_en), .core_run(core_run), .pmc_pending(pmc_pending)
    );

    function automatic logic [5:0] outs();
        return {osc_en, wdt_en, tmr_en, bod_en, lbd_en, core_run};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset();
        check("R1 enables", {26'd0, outs()}, 32'h3f);
        check("R1 pending", pmc_pending, 0);
    endtask

    task automatic t_idle_ovf();
        wr(1'b0, 8'h02);
        check("R3 idle enables", {26'd0, outs()}, 32'b111000);
        @(negedge clk); tmr_ovf = 1'b1;
        @(negedge clk); tmr_ovf = 1'b0;
        check("R7 resume next cycle", core_run, 1);
        check("R10 pending set", pmc_pending, 1);
        wr(1'b1, 8'h05);
        check("R10 nonzero clear ignored", pmc_pending, 1);
        wr(1'b1, 8'h00);
        check("R10 zero clears", pmc_pending, 0);
        repeat (10) @(negedge clk);
        check("R9 stays running", {26'd0, outs()}, 32'h3f);
    endtask

    task automatic t_idle_wake();
        wr(1'b0, 8'h02);
        wake_async = 1'b1;
        @(negedge clk); check("R8 sync stage 1", core_run, 0);
        @(negedge clk); check("R8 sync stage 2", core_run, 0);
        @(negedge clk); check("R8 wake resume", core_run, 1);
        wake_async = 1'b0;
        repeat (3) @(negedge clk);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_halt();
        int halt_n = 0, warm_n = 0;
        wr(1'b0, 8'h03);
        check("R4 both bits pick halt", {26'd0, outs()}, 0);
        @(negedge clk); tmr_ovf = 1'b1;
        @(negedge clk); tmr_ovf = 1'b0;
        repeat (5) begin
            @(negedge clk);
            check("R5 ovf ignored in halt", {26'd0, outs()}, 0);
        end
        check("R2 halt all off", {26'd0, outs()}, 0);
        wake_async = 1'b1;
        @(negedge clk);
        while (!osc_en && halt_n < 20) begin halt_n++; @(negedge clk); end
        check("R6 sync latency", halt_n, 2);
        check("R6 warm osc only", {26'd0, outs()}, 32'b100000);
        wake_async = 1'b0;
        while (!core_run && warm_n < 200) begin warm_n++; @(negedge clk); end
        check("R6 warm length", warm_n, WARM);
        check("R6 all on after warm", {26'd0, outs()}, 32'h3f);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_halt_prewake();
        int warm_n = 0;
        wake_async = 1'b1;
        repeat (3) @(negedge clk);
        wr(1'b0, 8'h01);
        check("R11 halt for one cycle", {26'd0, outs()}, 0);
        @(negedge clk);
        check("R11 immediate warm", {26'd0, outs()}, 32'b100000);
        wake_async = 1'b0;
        while (!core_run && warm_n < 200) begin warm_n++; @(negedge clk); end
        check("R11 warm length", warm_n, WARM);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle_ovf();
        t_idle_wake();
        t_halt();
        t_halt_prewake();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule